// File: doc/BRIEF.md
# Guarded Nonvolatile Write-Unlock Controller

This block stands between a processor's register bus and a small byte-addressable nonvolatile data array. It decides whether a requested array write may begin. A write starts only when four conditions hold together. The power-up lockout window must have ended. A two-byte key must have been written to the key register in the right order, with no other access after it. The control write that sets the start bit must also carry the enable bit. Any other attempt leaves the array untouched.

Software sets up a write by loading the address and data registers, writing 55h and then AAh to the key register, and writing the control register with the start and enable bits set. It then polls the start bit, which stays high for the fixed programming time of the array. Reads return the addressed byte into the data register through a read bit.

A synchronous warm reset aborts any write in flight and records this in a sticky error flag. A power-on reset clears all controller state but not the array contents.

Top module: `nvw_guard`

## Requirements
- R1: When `por_n` is asserted, the enable bit, the error flag, the start bit and the key tracker all clear. `lock_done` is low and the control register (select 2) reads 00h.
- R2: `lock_done` rises exactly LOCK_CYC clock edges after `por_n` is released or after a cycle with `warm_rst_n` low. Before that, a complete key and start sequence does not start a write.
- R3: Writing 55h and then AAh to the key register (select 3) arms the controller. Any other key value, or the two bytes in the other order, leaves it disarmed.
- R4: After the second key byte, any access other than a control write (a read strobe on any register, or a write to the address, data or key register) disarms the controller.
- R5: A write launches only on a control write with bit 1 (start) and bit 2 (enable) both set. With bit 2 clear, the array is unchanged.
- R6: Setting the start bit without an armed key sequence is ignored, and control bit 1 reads back 0.
- R7: After a launch, control bit 1 and `write_busy` read 1 for exactly WR_LAT cycles and then clear themselves. The array holds the new byte once they clear.
- R8: The address and data are captured at launch. Writes to the address or data register during the programming time do not change the byte written or its location.
- R9: A control write with bit 0 (read) set loads the data register (select 1) with the array byte at the current address on the next edge. Bit 0 always reads back 0.
- R10: A warm reset during a write aborts it, leaving the array unchanged, sets control bit 3 (error) and clears the enable bit. Writing 1 to bit 3 clears the flag. A warm reset while idle does not set the flag.
- R11: Select 0 reads the address register zero-extended to the data width, and only its low ADDR_W bits are stored. Select 3 (key) always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst_n | input | 1 | Synchronous warm reset, active low; aborts a write in flight |
| cpu_sel | input | 2 | Register select: 0 address, 1 data, 2 control, 3 key |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (counts as an access for the key tracker) |
| cpu_wdata | input | DATA_W | Register write data |
| cpu_rdata | output | DATA_W | Register read data for the selected register |
| lock_done | output | 1 | High once the power-up lockout has expired |
| write_busy | output | 1 | High while an array write is in progress |

## Verification
The bench tries each way a write can be refused: swapped key bytes, a wrong second byte, a repeated first byte, a clear enable bit, an intervening read or write, and a start during lockout. A design that forgot any of these checks would overwrite a byte the bench expects to be unchanged. It counts the busy window to the exact cycle and changes the address and data registers while a write is in progress. A design that did not capture them at launch would write the wrong location. It pulses warm reset both during a write and while idle. A design that committed the aborted byte, or set the error flag without cause, would fail the readback.

// File: rtl/nvw_guard_pkg.sv
package nvw_guard_pkg;

   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_DATA = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_KEY  = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      KS_IDLE  = 2'd0,
      KS_HALF  = 2'd1,
      KS_ARMED = 2'd2
   } key_state_e;

   localparam int CTRL_RD_BIT  = 0;
   localparam int CTRL_GO_BIT  = 1;
   localparam int CTRL_EN_BIT  = 2;
   localparam int CTRL_ERR_BIT = 3;

   localparam logic [7:0] KEY_FIRST  = 8'h55;
   localparam logic [7:0] KEY_SECOND = 8'hAA;

endpackage

// File: rtl/nvw_lockout_timer.sv
module nvw_lockout_timer #(
   parameter int LOCK_CYC = 20
) (
   input  logic clk,
   input  logic por_n,
   input  logic restart,
   output logic done
);
   localparam int CW = $clog2(LOCK_CYC + 1);

   if (LOCK_CYC < 1) begin : g_bad_lock
      $error("nvw_lockout_timer: LOCK_CYC must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (cnt_q != CW'(LOCK_CYC)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done = (cnt_q == CW'(LOCK_CYC));

endmodule

// File: rtl/nvw_key_tracker.sv
module nvw_key_tracker
   import nvw_guard_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              clear,
   input  logic              key_wr,
   input  logic              ctrl_wr,
   input  logic              other_acc,
   input  logic [DATA_W-1:0] wdata,
   output logic              armed
);
   localparam logic [DATA_W-1:0] K1 = DATA_W'(KEY_FIRST);
   localparam logic [DATA_W-1:0] K2 = DATA_W'(KEY_SECOND);

   key_state_e st_q, st_d;
   logic       any_acc;

   assign any_acc = key_wr | ctrl_wr | other_acc;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         KS_IDLE: begin
            if (key_wr && (wdata == K1)) st_d = KS_HALF;
         end
         KS_HALF: begin
            if (key_wr && (wdata == K2)) st_d = KS_ARMED;
            else if (any_acc)            st_d = KS_IDLE;
         end
         KS_ARMED: begin
            if (any_acc) st_d = KS_IDLE;
         end
         default: st_d = KS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         st_q <= KS_IDLE;
      end else if (clear) begin
         st_q <= KS_IDLE;
      end else begin
         st_q <= st_d;
      end
   end

   assign armed = (st_q == KS_ARMED);

endmodule

// File: rtl/nvw_array_model.sv
module nvw_array_model #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8,
   parameter int WR_LAT = 4
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              abort,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int LW    = $clog2(WR_LAT + 1);

   if (WR_LAT < 1) begin : g_bad_lat
      $error("nvw_array_model: WR_LAT must be at least 1");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [LW-1:0]     cnt_q;
   logic              busy_q;
   logic [ADDR_W-1:0] lat_addr_q;
   logic [DATA_W-1:0] lat_data_q;
   logic              commit;

   assign commit = busy_q && !abort && (cnt_q == LW'(1));

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         busy_q     <= 1'b0;
         cnt_q      <= '0;
         lat_addr_q <= '0;
         lat_data_q <= '0;
      end else if (abort) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!busy_q && wr_req) begin
         busy_q     <= 1'b1;
         cnt_q      <= LW'(WR_LAT);
         lat_addr_q <= wr_addr;
         lat_data_q <= wr_data;
      end else if (busy_q) begin
         if (cnt_q == LW'(1)) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (commit) begin
         mem[lat_addr_q] <= lat_data_q;
      end
   end

   assign rd_data = mem[rd_addr];
   assign busy    = busy_q;

endmodule

// File: rtl/nvw_guard.sv
module nvw_guard
   import nvw_guard_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 8,
   parameter int WR_LAT   = 4,
   parameter int LOCK_CYC = 20
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              warm_rst_n,
   input  logic [1:0]        cpu_sel,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              lock_done,
   output logic              write_busy
);
   if (DATA_W < 8) begin : g_bad_data
      $error("nvw_guard: DATA_W must hold an 8-bit key");
   end
   if (ADDR_W > DATA_W || ADDR_W < 1) begin : g_bad_addr
      $error("nvw_guard: ADDR_W must be between 1 and DATA_W");
   end

   logic              warm;
   logic              acc;
   logic              addr_wr, data_wr, ctrl_wr, key_wr, other_acc;
   logic              key_armed;
   logic              launch, rd_req;
   logic              busy;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              en_q;
   logic              err_q;
   logic [DATA_W-1:0] arr_rd_data;
   logic [DATA_W-1:0] addr_view;
   logic [DATA_W-1:0] ctrl_view;

   assign warm      = !warm_rst_n;
   assign acc       = cpu_wr | cpu_rd;
   assign addr_wr   = cpu_wr && (cpu_sel == SEL_ADDR);
   assign data_wr   = cpu_wr && (cpu_sel == SEL_DATA);
   assign ctrl_wr   = cpu_wr && (cpu_sel == SEL_CTRL);
   assign key_wr    = cpu_wr && (cpu_sel == SEL_KEY);
   assign other_acc = acc && !ctrl_wr && !key_wr;

   nvw_lockout_timer #(
      .LOCK_CYC(LOCK_CYC)
   ) i_lock (
      .clk    (clk),
      .por_n  (por_n),
      .restart(warm),
      .done   (lock_done)
   );

   nvw_key_tracker #(
      .DATA_W(DATA_W)
   ) i_keys (
      .clk      (clk),
      .por_n    (por_n),
      .clear    (warm),
      .key_wr   (key_wr),
      .ctrl_wr  (ctrl_wr),
      .other_acc(other_acc),
      .wdata    (cpu_wdata),
      .armed    (key_armed)
   );

   assign launch = ctrl_wr && cpu_wdata[CTRL_GO_BIT] && cpu_wdata[CTRL_EN_BIT]
                   && key_armed && lock_done && !busy && !warm;
   assign rd_req = ctrl_wr && cpu_wdata[CTRL_RD_BIT];

   nvw_array_model #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .WR_LAT(WR_LAT)
   ) i_array (
      .clk    (clk),
      .por_n  (por_n),
      .abort  (warm),
      .wr_req (launch),
      .wr_addr(addr_q),
      .wr_data(data_q),
      .rd_addr(addr_q),
      .rd_data(arr_rd_data),
      .busy   (busy)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         addr_q <= '0;
      end else if (addr_wr) begin
         addr_q <= cpu_wdata[ADDR_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         data_q <= '0;
      end else if (data_wr) begin
         data_q <= cpu_wdata;
      end else if (rd_req) begin
         data_q <= arr_rd_data;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         en_q <= 1'b0;
      end else if (warm) begin
         en_q <= 1'b0;
      end else if (ctrl_wr) begin
         en_q <= cpu_wdata[CTRL_EN_BIT];
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         err_q <= 1'b0;
      end else if (warm && busy) begin
         err_q <= 1'b1;
      end else if (ctrl_wr && cpu_wdata[CTRL_ERR_BIT]) begin
         err_q <= 1'b0;
      end
   end

   if (ADDR_W == DATA_W) begin : g_addr_full
      assign addr_view = addr_q;
   end else begin : g_addr_pad
      assign addr_view = {{(DATA_W - ADDR_W){1'b0}}, addr_q};
   end

   always_comb begin
      ctrl_view               = '0;
      ctrl_view[CTRL_GO_BIT]  = busy;
      ctrl_view[CTRL_EN_BIT]  = en_q;
      ctrl_view[CTRL_ERR_BIT] = err_q;
   end

   always_comb begin
      unique case (cpu_sel)
         SEL_ADDR: cpu_rdata = addr_view;
         SEL_DATA: cpu_rdata = data_q;
         SEL_CTRL: cpu_rdata = ctrl_view;
         default:  cpu_rdata = '0;
      endcase
   end

   assign write_busy = busy;

endmodule

// File: rtl/nvw_guard_chk.sv
module nvw_guard_chk #(
   parameter int WR_LAT = 4
) (
   input logic clk,
   input logic por_n,
   input logic warm_rst_n,
   input logic lock_done,
   input logic write_busy,
   input logic armed,
   input logic err,
   input logic go_en_wr
);
   localparam int BW = $clog2(WR_LAT + 2);

   logic [BW-1:0] bc;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)          bc <= '0;
      else if (write_busy) bc <= bc + 1'b1;
      else                 bc <= '0;
   end

   always @(negedge clk) begin
      if (!por_n) begin
         a_r1_reset_state: assert (!write_busy && !err && !armed && !lock_done)
            else $error("R1 reset state violated");
      end
   end

   a_r2_no_start_in_lockout: assert property (@(posedge clk) disable iff (!por_n)
      $rose(write_busy) |-> $past(lock_done));

   a_r3_start_needs_key: assert property (@(posedge clk) disable iff (!por_n)
      $rose(write_busy) |-> $past(armed));

   a_r5_start_needs_enable: assert property (@(posedge clk) disable iff (!por_n)
      $rose(write_busy) |-> $past(go_en_wr));

   a_r7_busy_length: assert property (@(posedge clk) disable iff (!por_n)
      ($fell(write_busy) && $past(warm_rst_n)) |-> (bc == BW'(WR_LAT)));

   a_r10_abort: assert property (@(posedge clk) disable iff (!por_n)
      !warm_rst_n |=> !write_busy);

   a_r10_err_set: assert property (@(posedge clk) disable iff (!por_n)
      (!warm_rst_n && write_busy) |=> err);

endmodule

bind nvw_guard nvw_guard_chk #(
   .WR_LAT(WR_LAT)
) i_nvw_guard_chk (
   .clk       (clk),
   .por_n     (por_n),
   .warm_rst_n(warm_rst_n),
   .lock_done (lock_done),
   .write_busy(write_busy),
   .armed     (key_armed),
   .err       (err_q),
   .go_en_wr  (cpu_wr && (cpu_sel == 2'd2) && cpu_wdata[1] && cpu_wdata[2])
);

// File: tb/test_nvw_guard.sv
module test_nvw_guard;
   localparam int ADDR_W   = 6;
   localparam int DATA_W   = 8;
   localparam int WR_LAT   = 4;
   localparam int LOCK_CYC = 20;

   localparam logic [1:0] S_ADDR = 2'd0;
   localparam logic [1:0] S_DATA = 2'd1;
   localparam logic [1:0] S_CTRL = 2'd2;
   localparam logic [1:0] S_KEY  = 2'd3;

   typedef struct packed {
      logic [7:0] k1;
      logic [7:0] k2;
      logic       en;
      logic [5:0] addr;
      logic [7:0] data;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{8'h55, 8'hAA, 1'b1, 6'd1,  8'hA1},
      '{8'h55, 8'hAA, 1'b1, 6'd2,  8'hB2},
      '{8'hAA, 8'h55, 1'b1, 6'd1,  8'hFF},
      '{8'h55, 8'hAA, 1'b0, 6'd2,  8'h00},
      '{8'h55, 8'h56, 1'b1, 6'd2,  8'hC3},
      '{8'h55, 8'h55, 1'b1, 6'd1,  8'hD4},
      '{8'h55, 8'hAA, 1'b1, 6'd3,  8'h5A},
      '{8'h55, 8'hAA, 1'b1, 6'd63, 8'h7E}
   };

   logic              clk = 1'b0;
   logic              por_n = 1'b0;
   logic              warm_rst_n = 1'b1;
   logic [1:0]        cpu_sel = 2'd0;
   logic              cpu_wr = 1'b0;
   logic              cpu_rd = 1'b0;
   logic [DATA_W-1:0] cpu_wdata = '0;
   logic [DATA_W-1:0] cpu_rdata;
   logic              lock_done;
   logic              write_busy;

   int checks = 0;
   int fails  = 0;
   logic [7:0] shadow [64];

   always #5 clk = ~clk;

   nvw_guard #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_LAT(WR_LAT), .LOCK_CYC(LOCK_CYC)
   ) i_nvw_guard (
      .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n),
      .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .lock_done(lock_done), .write_busy(write_busy)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] s, input logic [7:0] v);
      @(negedge clk);
      cpu_sel = s; cpu_wdata = v; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic reg_touch(input logic [1:0] s);
      @(negedge clk);
      cpu_sel = s; cpu_rd = 1'b1;
      @(negedge clk);
      cpu_rd = 1'b0;
   endtask

   task automatic peek(input logic [1:0] s, output logic [7:0] d);
      cpu_sel = s;
      #1;
      d = cpu_rdata;
   endtask

   task automatic read_byte(input logic [5:0] a, output logic [7:0] d);
      reg_write(S_ADDR, {2'b00, a});
      reg_write(S_CTRL, 8'h01);
      peek(S_DATA, d);
   endtask

   task automatic attempt(input logic [7:0] k1, input logic [7:0] k2, input logic en,
                          input logic [5:0] a, input logic [7:0] d);
      reg_write(S_ADDR, {2'b00, a});
      reg_write(S_DATA, d);
      reg_write(S_CTRL, {5'b0, en, 2'b00});
      reg_write(S_KEY, k1);
      reg_write(S_KEY, k2);
      reg_write(S_CTRL, {5'b0, en, 2'b10});
   endtask

   task automatic pulse_warm();
      warm_rst_n = 1'b0;
      @(negedge clk);
      warm_rst_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      logic [7:0] rv;
      vec_t v;
      logic go;

      repeat (3) @(posedge clk);
      @(negedge clk);
      por_n = 1'b1;

      // R1: state after power-on reset
      peek(S_CTRL, rv);
      chk("R1 control after reset", rv, 8'h00);
      chk("R1 lock_done after reset", {7'b0, lock_done}, 8'h00);

      // R2: lockout expires exactly LOCK_CYC edges after release
      repeat (LOCK_CYC - 1) @(negedge clk);
      chk("R2 lockout one cycle early", {7'b0, lock_done}, 8'h00);
      @(negedge clk);
      chk("R2 lockout expiry", {7'b0, lock_done}, 8'h01);

      // Vector table: R3 key order, R5 enable, R6 ignored start, R9 read back
      for (int i = 0; i < 8; i++) begin
         v  = VECS[i];
         go = v.en && (v.k1 == 8'h55) && (v.k2 == 8'hAA);
         attempt(v.k1, v.k2, v.en, v.addr, v.data);
         chk($sformatf("R3/R5 vec%0d busy after start", i), {7'b0, write_busy}, {7'b0, go});
         peek(S_CTRL, rv);
         chk($sformatf("R6 vec%0d start bit readback", i), {7'b0, rv[1]}, {7'b0, go});
         repeat (WR_LAT + 1) @(negedge clk);
         chk($sformatf("R7 vec%0d busy cleared", i), {7'b0, write_busy}, 8'h00);
         if (go) shadow[v.addr] = v.data;
         read_byte(v.addr, rv);
         chk($sformatf("R9 vec%0d array byte", i), rv, shadow[v.addr]);
         peek(S_CTRL, rv);
         chk($sformatf("R9 vec%0d read bit reads 0", i), {7'b0, rv[0]}, 8'h00);
      end

      // R7: exact busy window
      attempt(8'h55, 8'hAA, 1'b1, 6'd5, 8'h6E);
      chk("R7 busy at launch", {7'b0, write_busy}, 8'h01);
      repeat (WR_LAT - 1) @(negedge clk);
      chk("R7 busy on last cycle", {7'b0, write_busy}, 8'h01);
      @(negedge clk);
      chk("R7 busy cleared after WR_LAT", {7'b0, write_busy}, 8'h00);
      shadow[5] = 8'h6E;
      read_byte(6'd5, rv);
      chk("R7 committed byte", rv, 8'h6E);

      // R8: address and data captured at launch
      attempt(8'h55, 8'hAA, 1'b1, 6'd4, 8'h44);
      reg_write(S_ADDR, 8'd2);
      reg_write(S_DATA, 8'h99);
      repeat (WR_LAT) @(negedge clk);
      shadow[4] = 8'h44;
      read_byte(6'd4, rv);
      chk("R8 launched location written", rv, 8'h44);
      read_byte(6'd2, rv);
      chk("R8 other location untouched", rv, shadow[2]);

      // R4: intervening write between key and start
      reg_write(S_ADDR, 8'd1);
      reg_write(S_DATA, 8'h0F);
      reg_write(S_CTRL, 8'h04);
      reg_write(S_KEY, 8'h55);
      reg_write(S_KEY, 8'hAA);
      reg_write(S_DATA, 8'h0F);
      reg_write(S_CTRL, 8'h06);
      chk("R4 write access disarms", {7'b0, write_busy}, 8'h00);
      // R4: intervening read strobe
      reg_write(S_KEY, 8'h55);
      reg_write(S_KEY, 8'hAA);
      reg_touch(S_ADDR);
      reg_write(S_CTRL, 8'h06);
      chk("R4 read access disarms", {7'b0, write_busy}, 8'h00);
      repeat (WR_LAT + 1) @(negedge clk);
      read_byte(6'd1, rv);
      chk("R4 array unchanged", rv, shadow[1]);

      // R11: register map readback
      reg_write(S_ADDR, 8'hFF);
      peek(S_ADDR, rv);
      chk("R11 address zero-extended", rv, 8'h3F);
      reg_write(S_KEY, 8'h5C);
      peek(S_KEY, rv);
      chk("R11 key reads zero", rv, 8'h00);

      // R10: warm reset during a write
      attempt(8'h55, 8'hAA, 1'b1, 6'd3, 8'hEE);
      chk("R10 write launched", {7'b0, write_busy}, 8'h01);
      pulse_warm();
      chk("R10 busy aborted", {7'b0, write_busy}, 8'h00);
      peek(S_CTRL, rv);
      chk("R10 error set and enable cleared", rv, 8'h08);
      repeat (LOCK_CYC + 1) @(negedge clk);
      read_byte(6'd3, rv);
      chk("R10 aborted byte not committed", rv, shadow[3]);
      reg_write(S_CTRL, 8'h08);
      peek(S_CTRL, rv);
      chk("R10 error cleared by writing 1", rv, 8'h00);

      // R10: warm reset while idle; R2: lockout after warm reset
      @(negedge clk);
      pulse_warm();
      peek(S_CTRL, rv);
      chk("R10 idle warm reset leaves error clear", rv, 8'h00);
      attempt(8'h55, 8'hAA, 1'b1, 6'd3, 8'h77);
      chk("R2 start ignored in lockout", {7'b0, write_busy}, 8'h00);
      chk("R2 lockout still running", {7'b0, lock_done}, 8'h00);
      repeat (LOCK_CYC) @(negedge clk);
      chk("R2 lockout expired again", {7'b0, lock_done}, 8'h01);
      read_byte(6'd3, rv);
      chk("R2 array unchanged after lockout attempt", rv, shadow[3]);
      attempt(8'h55, 8'hAA, 1'b1, 6'd3, 8'h77);
      chk("R2 start accepted after lockout", {7'b0, write_busy}, 8'h01);
      repeat (WR_LAT) @(negedge clk);
      shadow[3] = 8'h77;
      read_byte(6'd3, rv);
      chk("R2 byte written after lockout", rv, 8'h77);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule